// File: doc/BRIEF.md
# Two-Phase Self-Test Session Sequencer

This block runs an offline self-test of two logic blocks that share a pair of reconfigurable test registers. A pulse on the start pin while the sequencer is idle begins a session. From then until the end of the session the normal function of both logic blocks is suspended. The sequencer drives a mode code to each test register and a select line to the input multiplexer of each logic block. When a select line is high, that block takes register-generated patterns in place of its primary inputs.

A session has two phases. In the first phase, test register 1 produces patterns for logic block 1 and test register 2 folds block 1's responses into a signature. In the second phase the two roles are swapped, and block 2 is the one under test. Each phase loads fixed seeds into both registers, applies a parameterised number of pattern clocks, and then freezes the registers for one cycle. During that cycle the compacting register's contents are compared with a reference constant for that phase. The test registers, the logic blocks and their multiplexers sit outside this block.

The session ends with a one-cycle done pulse. The pass output is high only if both phase signatures matched. All pins are plain control and status lines. There is no streamed data, so no valid/ready handshake is involved.

Top module: `bist_session_ctrl`

## Requirements
- R1: Mode codes are NORMAL=0, HOLD=1, SEED=2, GEN=3, COMPACT=4. While reset is held, and whenever no session is running, busy, done and pass-after-reset are 0, both mode outputs are NORMAL (0) and both select lines are 0.
- R2: When start is sampled high while idle, busy rises on the next cycle. Busy stays high through the cycle in which done is high and falls on the cycle after.
- R3: The first session cycle is phase-A seeding: both modes are SEED (2), select 1 is high and select 2 is low.
- R4: Phase A then runs for exactly PATTERNS cycles. Register 1 is GEN (3), register 2 is COMPACT (4), select 1 is high and select 2 is low.
- R5: Phase A ends with one check cycle in which both modes are HOLD (1) and select 1 stays high. Register 2's signature input, sampled in that cycle, is compared with REF_A.
- R6: Phase B seeding follows for one cycle: both modes are SEED (2), select 2 is high and select 1 is low.
- R7: Phase B runs for exactly PATTERNS cycles. Register 2 is GEN (3), register 1 is COMPACT (4), select 2 is high and select 1 is low.
- R8: Phase B ends with one check cycle in which both modes are HOLD (1) and select 2 stays high. Register 1's signature input, sampled in that cycle, is compared with REF_B.
- R9: The next cycle is the final one. Done is high for that one cycle only, both modes are HOLD and both selects are low. A session therefore keeps busy high for 2*PATTERNS+5 cycles.
- R10: Pass is cleared on the cycle after a start is accepted. It reads 0 during the session. It is 1 from the done cycle onward only if both comparisons matched, and it holds its value until the next accepted start.
- R11: A start pulse that arrives while busy is high has no effect on the sequence, its timing or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Session request, sampled while idle |
| tr1_sig_i | input | SIG_W | Current contents of test register 1 |
| tr2_sig_i | input | SIG_W | Current contents of test register 2 |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle end-of-session pulse |
| pass_o | output | 1 | Both signatures matched their references |
| tr1_mode_o | output | 3 | Mode code for test register 1 |
| tr2_mode_o | output | 3 | Mode code for test register 2 |
| cut1_test_sel_o | output | 1 | Logic block 1 input multiplexer takes patterns |
| cut2_test_sel_o | output | 1 | Logic block 2 input multiplexer takes patterns |

## Verification
The properties assume that reset is applied before the first start. Beyond that they place no limit on start: it may be high on any cycle, including a cycle where busy is high or the done cycle, and the sequence must be unaffected. The signature inputs are treated as arbitrary, because only their values in the two check cycles matter. The stimulus drives random start pulses throughout sessions and random signature values on every other cycle. In the check cycles it forces either the exact reference or the reference with random bits flipped, so that every pass/fail combination appears.

// File: rtl/bist_sess_pkg.sv
package bist_sess_pkg;
  typedef enum logic [2:0] {
    TR_NORMAL  = 3'd0,
    TR_HOLD    = 3'd1,
    TR_SEED    = 3'd2,
    TR_GEN     = 3'd3,
    TR_COMPACT = 3'd4
  } tr_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_A_SEED, S_A_RUN, S_A_CHK, S_B_SEED, S_B_RUN, S_B_CHK, S_FIN
  } sess_state_e;
endpackage

// File: rtl/bist_step_counter.sv
module bist_step_counter #(
  parameter int PATTERNS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(PATTERNS + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign last_o = run_i && (cnt_q == CNT_W'(PATTERNS - 1));
endmodule

// File: rtl/bist_phase_fsm.sv
module bist_phase_fsm
  import bist_sess_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        last_i,
  output sess_state_e state_o
);
  sess_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (start_i) st_d = S_A_SEED;
      S_A_SEED: st_d = S_A_RUN;
      S_A_RUN:  if (last_i) st_d = S_A_CHK;
      S_A_CHK:  st_d = S_B_SEED;
      S_B_SEED: st_d = S_B_RUN;
      S_B_RUN:  if (last_i) st_d = S_B_CHK;
      S_B_CHK:  st_d = S_FIN;
      S_FIN:    st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/bist_reg_role.sv
module bist_reg_role
  import bist_sess_pkg::*;
#(
  parameter bit OWN_B = 1'b0
) (
  input  sess_state_e state_i,
  output tr_mode_e    mode_o,
  output logic        sel_o
);
  logic in_a, in_b, own;

  always_comb begin
    in_a = (state_i == S_A_SEED) || (state_i == S_A_RUN) || (state_i == S_A_CHK);
    in_b = (state_i == S_B_SEED) || (state_i == S_B_RUN) || (state_i == S_B_CHK);
    own  = OWN_B ? in_b : in_a;
    sel_o = own;
    unique case (state_i)
      S_IDLE:             mode_o = TR_NORMAL;
      S_A_SEED, S_B_SEED: mode_o = TR_SEED;
      S_A_RUN, S_B_RUN:   mode_o = own ? TR_GEN : TR_COMPACT;
      default:            mode_o = TR_HOLD;
    endcase
  end
endmodule

// File: rtl/bist_verdict.sv
module bist_verdict #(
  parameter int             SIG_W = 16,
  parameter logic [SIG_W-1:0] REF_A = '1,
  parameter logic [SIG_W-1:0] REF_B = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             chk_a_i,
  input  logic             chk_b_i,
  input  logic [SIG_W-1:0] sig_a_i,
  input  logic [SIG_W-1:0] sig_b_i,
  output logic             pass_o
);
  logic ok_a_q, pass_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      ok_a_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      if (chk_a_i) ok_a_q <= (sig_a_i == REF_A);
      if (chk_b_i) pass_q <= ok_a_q && (sig_b_i == REF_B);
    end
  end

  assign pass_o = pass_q;
endmodule

// File: rtl/bist_session_ctrl.sv
module bist_session_ctrl
  import bist_sess_pkg::*;
#(
  parameter int               SIG_W    = 16,
  parameter int               PATTERNS = 1000,
  parameter logic [SIG_W-1:0] REF_A    = 16'hC3A5,
  parameter logic [SIG_W-1:0] REF_B    = 16'h5E17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SIG_W-1:0] tr1_sig_i,
  input  logic [SIG_W-1:0] tr2_sig_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic [2:0]       tr1_mode_o,
  output logic [2:0]       tr2_mode_o,
  output logic             cut1_test_sel_o,
  output logic             cut2_test_sel_o
);
  localparam int NREG = 2;

  sess_state_e state;
  logic        last, run;
  tr_mode_e    mode_w [NREG];
  logic        sel_w  [NREG];

  assign run = (state == S_A_RUN) || (state == S_B_RUN);

  bist_step_counter #(.PATTERNS(PATTERNS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .last_o(last)
  );

  bist_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last), .state_o(state)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_role
    bist_reg_role #(.OWN_B(r == 1)) u_role (
      .state_i(state), .mode_o(mode_w[r]), .sel_o(sel_w[r])
    );
  end

  bist_verdict #(.SIG_W(SIG_W), .REF_A(REF_A), .REF_B(REF_B)) u_verdict (
    .clk(clk), .rst_n(rst_n),
    .clear_i((state == S_IDLE) && start_i),
    .chk_a_i(state == S_A_CHK),
    .chk_b_i(state == S_B_CHK),
    .sig_a_i(tr2_sig_i),
    .sig_b_i(tr1_sig_i),
    .pass_o(pass_o)
  );

  assign busy_o          = (state != S_IDLE);
  assign done_o          = (state == S_FIN);
  assign tr1_mode_o      = mode_w[0];
  assign tr2_mode_o      = mode_w[1];
  assign cut1_test_sel_o = sel_w[0];
  assign cut2_test_sel_o = sel_w[1];
endmodule

// File: rtl/bist_session_chk.sv
module bist_session_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       pass_o,
  input logic [2:0] tr1_mode_o,
  input logic [2:0] tr2_mode_o,
  input logic       cut1_test_sel_o,
  input logic       cut2_test_sel_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (tr1_mode_o == 3'd0 && tr2_mode_o == 3'd0 && !cut1_test_sel_o && !cut2_test_sel_o));

  p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  p_seed_then_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tr1_mode_o == 3'd2 && cut1_test_sel_o) |=> (tr1_mode_o == 3'd3 && tr2_mode_o == 3'd4));

  p_seed_then_gen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tr2_mode_o == 3'd2 && cut2_test_sel_o) |=> (tr2_mode_o == 3'd3 && tr1_mode_o == 3'd4));

  p_sel_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cut1_test_sel_o && cut2_test_sel_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  p_pass_low_in_session_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |-> !pass_o);

  p_pass_holds_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(pass_o));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

bind bist_session_ctrl bist_session_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .pass_o(pass_o), .tr1_mode_o(tr1_mode_o), .tr2_mode_o(tr2_mode_o),
  .cut1_test_sel_o(cut1_test_sel_o), .cut2_test_sel_o(cut2_test_sel_o)
);

// File: tb/bist_session_ctrl_test.sv
module bist_session_ctrl_test;
  localparam int          CLK_P = 10;
  localparam int          W     = 16;
  localparam int          N     = 6;
  localparam logic [W-1:0] RA   = 16'hC3A5;
  localparam logic [W-1:0] RB   = 16'h5E17;
  localparam int          LAST  = 2 * N + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] sig1 = '0, sig2 = '0;
  logic busy, done, pass, s1, s2;
  logic [2:0] m1, m2;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  bist_session_ctrl #(.SIG_W(W), .PATTERNS(N), .REF_A(RA), .REF_B(RB)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tr1_sig_i(sig1), .tr2_sig_i(sig2),
    .busy_o(busy), .done_o(done), .pass_o(pass), .tr1_mode_o(m1), .tr2_mode_o(m2),
    .cut1_test_sel_o(s1), .cut2_test_sel_o(s2)
  );

  // packing: {busy, done, pass, mode1, mode2, sel1, sel2}
  function automatic logic [10:0] exp_vec(int k, bit p);
    logic [2:0] e1, e2;
    logic b, d, q, x1, x2;
    b = 1'b1; d = 1'b0; q = 1'b0; x1 = 1'b0; x2 = 1'b0;
    if (k == 0)             begin b = 1'b0; e1 = 3'd0; e2 = 3'd0; q = p; end
    else if (k == 1)        begin e1 = 3'd2; e2 = 3'd2; x1 = 1'b1; end
    else if (k <= N + 1)    begin e1 = 3'd3; e2 = 3'd4; x1 = 1'b1; end
    else if (k == N + 2)    begin e1 = 3'd1; e2 = 3'd1; x1 = 1'b1; end
    else if (k == N + 3)    begin e1 = 3'd2; e2 = 3'd2; x2 = 1'b1; end
    else if (k <= 2 * N + 3) begin e1 = 3'd4; e2 = 3'd3; x2 = 1'b1; end
    else if (k == 2 * N + 4) begin e1 = 3'd1; e2 = 3'd1; x2 = 1'b1; end
    else                    begin e1 = 3'd1; e2 = 3'd1; d = 1'b1; q = p; end
    return {b, d, q, e1, e2, x1, x2};
  endfunction

  function automatic string req_of(int k);
    if (k == 0)              return "R1/R2/R10 idle";
    if (k == 1)              return "R3/R10";
    if (k <= N + 1)          return "R4";
    if (k == N + 2)          return "R5";
    if (k == N + 3)          return "R6";
    if (k <= 2 * N + 3)      return "R7";
    if (k == 2 * N + 4)      return "R8";
    return "R9/R10";
  endfunction

  task automatic check(string req, logic [10:0] exp);
    logic [10:0] act;
    act = {busy, done, pass, m1, m2, s1, s2};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // entered just after a clock edge while idle
  task automatic session(bit good_a, bit good_b, bit poke);
    bit p;
    p = good_a && good_b;
    start = 1'b1;
    @(posedge clk); #1;
    for (int k = 1; k <= LAST; k++) begin
      check(req_of(k), exp_vec(k, p));
      sig1 = W'($urandom);
      sig2 = W'($urandom);
      if (k == N + 2)     sig2 = good_a ? RA : (RA ^ (W'($urandom) | 16'h1));
      if (k == 2 * N + 4) sig1 = good_b ? RB : (RB ^ (W'($urandom) | 16'h8000));
      start = poke ? 1'($urandom) : 1'b0; // R11: ignored while busy
      @(posedge clk); #1;
    end
    start = 1'b0;
    check(req_of(0), exp_vec(0, p));
    @(posedge clk); #1;
    check("R10 hold", exp_vec(0, p));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    start = 1'b1; // start held during reset must do nothing
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 11'b0);
    start = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle", 11'b0);
    session(1'b1, 1'b1, 1'b0);
    session(1'b0, 1'b1, 1'b0);
    session(1'b1, 1'b0, 1'b1);
    session(1'b0, 1'b0, 1'b1);
    session(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 30; i++) begin
      session(1'($urandom), 1'($urandom), 1'($urandom));
      repeat ($urandom_range(0, 2)) begin
        @(posedge clk); #1;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule